// File: doc/BRIEF.md
# Prefix Register with Address Extension

This block holds a single-use prefix for the instruction that follows the one that writes it. A write presents a 3-bit index and a 16-bit value. The low byte of the stored value becomes the high-order immediate byte for the next instruction. The index is split to widen that instruction's short register fields into 5-bit source and destination addresses.

The stored value and index stay valid until the next instruction-advance strobe, which marks the end of an execution cycle. They then fall back to zero. With a zero prefix the source range is 0h–Fh and the destination range is 0h–7h.

A write in the same cycle as an advance replaces the expiring prefix, so the newly written value reaches the next instruction. Instruction decode and the register file sit outside this block.

Top module: `pfx_extend_unit`

## Requirements
- R1: `imm_hi` always equals bits 7:0 of the stored 16-bit prefix value.
- R2: A write (`wr_en` high at a clock edge) loads `wr_data` and `wr_idx`, and they are visible from the next cycle. Every index value writes the same single register, and `rd_data` returns all 16 stored bits.
- R3: A clock edge with `adv` high and `wr_en` low clears both the stored value and the stored index to zero.
- R4: A clock edge with both `adv` and `wr_en` low leaves the stored value and index unchanged.
- R5: `src_addr` is {stored index bit 0, `src_fld[3:0]`}. Index bit 0 = 1 selects sources 10h–1Fh, and 0 selects 0h–Fh.
- R6: `dst_addr` is {stored index bits 2:1, `dst_fld[2:0]`}. The destination block of eight is selected as 0h–7h, 8h–Fh, 10h–17h or 18h–1Fh.
- R7: When `wr_en` and `adv` are both high at the same edge, the newly written value and index are stored.
- R8: A clock edge with `rst_n` low clears the stored value and index to zero, overriding any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Prefix write strobe |
| wr_idx | input | 3 | Index accompanying the write |
| wr_data | input | 16 | Prefix data to store |
| adv | input | 1 | Instruction-advance strobe (end of an execution cycle) |
| src_fld | input | 4 | Short source register field of the current instruction |
| dst_fld | input | 3 | Short destination register field of the current instruction |
| rd_data | output | 16 | Stored prefix value |
| imm_hi | output | 8 | High-order immediate byte |
| src_addr | output | 5 | Extended source register address |
| dst_addr | output | 5 | Extended destination register address |

## Verification
A wrong stored value appears on `rd_data` and `imm_hi` in the first cycle after the faulty edge. A wrong stored index appears on the top bits of `src_addr` and `dst_addr` in that same cycle. A prefix that fails to expire shows up one cycle after an advance without a write, as a nonzero readback or a widened address. A lost overlap write shows up as zero where the new value was expected. The bench runs a behavioural model in step with the design and compares every output on every cycle, so a fault is reported within one cycle of the edge that caused it.

// File: rtl/pfx_pkg.sv
// Package: default widths shared by the prefix block and its bench.
// Assumes: index bit 0 extends the source field; the remaining index bits
// extend the destination field.
package pfx_pkg;
    localparam int DATA_W_DEF = 16;
    localparam int IMM_W_DEF  = 8;
    localparam int IDX_W_DEF  = 3;
    localparam int SRC_F_DEF  = 4;
    localparam int DST_F_DEF  = 3;

    // Next-state choice for the holding register
    typedef enum logic [1:0] {
        PFX_HOLD  = 2'd0,
        PFX_LOAD  = 2'd1,
        PFX_CLEAR = 2'd2
    } pfx_act_e;
endpackage

// File: rtl/pfx_hold.sv
// Module: pfx_hold
// Holds the prefix value and its index for one execution cycle.
// Assumes: synchronous active-low reset; a write wins over expiry; adv marks
// the end of an execution cycle.
module pfx_hold
    import pfx_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int IDX_W  = IDX_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              adv,
    output logic [DATA_W-1:0] val_q,
    output logic [IDX_W-1:0]  idx_q
);
    pfx_act_e act;

    // Pick the register action: load beats clear, clear beats hold
    always_comb begin
        if (wr_en)    act = PFX_LOAD;
        else if (adv) act = PFX_CLEAR;
        else          act = PFX_HOLD;
    end

    // Update the stored value and index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
            idx_q <= '0;
        end else begin
            case (act)
                PFX_LOAD: begin
                    val_q <= wr_data;
                    idx_q <= wr_idx;
                end
                PFX_CLEAR: begin
                    val_q <= '0;
                    idx_q <= '0;
                end
                default: begin
                    val_q <= val_q;
                    idx_q <= idx_q;
                end
            endcase
        end
    end

    // R2
    load_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (val_q == $past(wr_data)) && (idx_q == $past(wr_idx)));
    // R3
    expire_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_en) |=> (val_q == '0) && (idx_q == '0));
    // R4
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !wr_en) |=> $stable(val_q) && $stable(idx_q));
endmodule

// File: rtl/pfx_addr_ext.sv
// Module: pfx_addr_ext
// Widens the short register fields using the stored index, and slices the
// immediate byte out of the stored value.
// Assumes: index bit 0 feeds the source; the upper index bits feed the
// destination; IMM_W <= DATA_W.
module pfx_addr_ext #(
    parameter int DATA_W = 16,
    parameter int IMM_W  = 8,
    parameter int IDX_W  = 3,
    parameter int SRC_F  = 4,
    parameter int DST_F  = 3,
    localparam int SRC_A = SRC_F + 1,
    localparam int DST_A = DST_F + IDX_W - 1
) (
    input  logic [DATA_W-1:0] val,
    input  logic [IDX_W-1:0]  idx,
    input  logic [SRC_F-1:0]  src_fld,
    input  logic [DST_F-1:0]  dst_fld,
    output logic [IMM_W-1:0]  imm_hi,
    output logic [SRC_A-1:0]  src_addr,
    output logic [DST_A-1:0]  dst_addr
);
    // Immediate byte: take the whole value when the widths match
    generate
        if (IMM_W == DATA_W) begin : g_imm_full
            assign imm_hi = val;
        end else begin : g_imm_slice
            assign imm_hi = val[IMM_W-1:0];
        end
    endgenerate

    // Source: index bit 0 is the top bit above the short field
    always_comb src_addr = {idx[0], src_fld};

    // Destination: the remaining index bits sit above the short field
    always_comb dst_addr = {idx[IDX_W-1:1], dst_fld};
endmodule

// File: rtl/pfx_extend_unit.sv
// Module: pfx_extend_unit (top)
// One-shot prefix register. It supplies a high immediate byte and extended
// register addresses to the next instruction.
// Assumes: synchronous active-low reset; adv pulses once per executed
// instruction.
module pfx_extend_unit
    import pfx_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int IMM_W  = IMM_W_DEF,
    parameter int IDX_W  = IDX_W_DEF,
    parameter int SRC_F  = SRC_F_DEF,
    parameter int DST_F  = DST_F_DEF,
    localparam int SRC_A = SRC_F + 1,
    localparam int DST_A = DST_F + IDX_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              adv,
    input  logic [SRC_F-1:0]  src_fld,
    input  logic [DST_F-1:0]  dst_fld,
    output logic [DATA_W-1:0] rd_data,
    output logic [IMM_W-1:0]  imm_hi,
    output logic [SRC_A-1:0]  src_addr,
    output logic [DST_A-1:0]  dst_addr
);
    logic [DATA_W-1:0] val_q;
    logic [IDX_W-1:0]  idx_q;

    pfx_hold #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .adv     (adv),
        .val_q   (val_q),
        .idx_q   (idx_q)
    );

    pfx_addr_ext #(
        .DATA_W(DATA_W), .IMM_W(IMM_W), .IDX_W(IDX_W),
        .SRC_F(SRC_F), .DST_F(DST_F)
    ) i_ext (
        .val      (val_q),
        .idx      (idx_q),
        .src_fld  (src_fld),
        .dst_fld  (dst_fld),
        .imm_hi   (imm_hi),
        .src_addr (src_addr),
        .dst_addr (dst_addr)
    );

    // Readback of the full stored value
    always_comb rd_data = val_q;

    // R7
    overlap_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && adv) |=> (rd_data == $past(wr_data)));
    // R5
    src_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_en) |=> (src_addr[SRC_A-1] == 1'b0));
    // R6
    dst_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_en) |=> (dst_addr[DST_A-1:DST_F] == '0));
    // R1
    imm_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (imm_hi == $past(wr_data[IMM_W-1:0])));
endmodule

// File: tb/test_pfx_extend_unit.sv
`timescale 1ns/1ps
module test_pfx_extend_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [15:0] wr_data = '0;
    logic        adv = 1'b0;
    logic [3:0]  src_fld = '0;
    logic [2:0]  dst_fld = '0;
    logic [15:0] rd_data;
    logic [7:0]  imm_hi;
    logic [4:0]  src_addr;
    logic [4:0]  dst_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference state
    int m_val = 0;
    int m_idx = 0;
    string last_tag = "R8";

    always #2.5 clk = ~clk;

    pfx_extend_unit i_pfx_extend_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .adv(adv), .src_fld(src_fld), .dst_fld(dst_fld),
        .rd_data(rd_data), .imm_hi(imm_hi), .src_addr(src_addr),
        .dst_addr(dst_addr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // compare all outputs against the model (called at negedge)
    task automatic compare_all();
        chk(last_tag, int'(rd_data), m_val);
        chk("R1", int'(imm_hi), m_val % 256);
        chk("R5", int'(src_addr), (m_idx % 2) * 16 + int'(src_fld));
        chk("R6", int'(dst_addr), (m_idx / 2) * 8 + int'(dst_fld));
    endtask

    // drive one cycle, advance model at posedge, compare at negedge
    task automatic step(input bit w, input int idx, input int data, input bit a,
                        input bit rst);
        wr_en = w; wr_idx = 3'(idx); wr_data = 16'(data); adv = a;
        rst_n = !rst;
        src_fld = 4'($urandom); dst_fld = 3'($urandom);
        @(posedge clk);
        if (rst)          begin m_val = 0;    m_idx = 0;   last_tag = "R8"; end
        else if (w && a)  begin m_val = data; m_idx = idx; last_tag = "R7"; end
        else if (w)       begin m_val = data; m_idx = idx; last_tag = "R2"; end
        else if (a)       begin m_val = 0;    m_idx = 0;   last_tag = "R3"; end
        else              last_tag = "R4";
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        @(negedge clk);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1);   // R8 reset state
        step(1, 5, 16'hA55A, 0, 0); // R2 write, index 5
        step(0, 0, 0, 0, 0);   // R4 hold
        step(0, 0, 0, 1, 0);   // R3 expire
        for (int i = 0; i < 8; i++) begin // R5 R6 every index
            step(1, i, 16'h1234 + i * 16'h0101, 0, 0);
            step(0, 0, 0, 1, 0);
        end
        step(1, 7, 16'hFFFF, 1, 0);   // R7 overlap
        step(1, 2, 16'h00C3, 1, 0);   // R7 back to back
        step(1, 6, 16'hBEEF, 0, 0);
        step(1, 1, 16'h7777, 1, 1);   // R8 reset beats write
        for (int i = 0; i < 3000; i++)
            step($urandom % 3 == 0, $urandom % 8, $urandom % 65536,
                 $urandom % 2, $urandom % 97 == 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule